// File: doc/BRIEF.md
# Bus data-float turnaround scheduler

This block sits in front of the access sequencer of an external static memory controller. After a read, the device that was read keeps driving the shared data bus for a while as its output buffers turn off. Each chip select carries a programmed count of cycles for this float time. The scheduler tracks how much of that time is still outstanding for every chip select. When the sequencer presents its next access, the scheduler works out how many idle cycles must come first. It then holds a stall request for that many cycles and raises a start-permitted strobe.

The hold cycles of the finished read count as float time that has already elapsed. A chip select whose mode bit is set also lets the setup phase of the following access absorb remaining float cycles. Float waits apply only when the next access targets a chip select other than the one that was read. A read followed by a write adds one more bus turnaround cycle on top of any float waits.

The sequencer pulses `rd_end` in the last cycle of a read, which is the last hold cycle, and gives the hold length with it. It raises `req_valid` with the attributes of the next access and keeps them stable until `go` is high.

Top module: `float_gap_sched`

## Requirements
- R1: After reset no float time is outstanding and no read is recorded. The first request after reset, of either type and to any chip select, gets `go`=1 in its first cycle with `stall`=0.
- R2: In a cycle with `rd_end`=1, chip select `rd_cs` gets an outstanding float count of max(0, float count − `rd_hold`). The float count is `float_cfg[cs*CW +: CW]`.
- R3: Each outstanding float count falls by one per clock cycle after it is loaded, and stops at zero.
- R4: When `opt_cfg[i]`=0, chip select i adds its full outstanding float count to the wait needed by a request.
- R5: When `opt_cfg[i]`=1, chip select i adds max(0, outstanding − `req_setup`) to the wait needed.
- R6: The outstanding float count of the chip select named by `req_cs` is ignored.
- R7: When several other chip selects have float time outstanding, the float wait is the largest of their contributions.
- R8: A request with `req_write`=1 needs one extra turnaround cycle when a read has ended since the last `go`. The chip select of that read does not matter, and a read ending in the same cycle counts.
- R9: Let the total wait of an accepted request be N. If N=0, `go`=1 in the cycle the request is accepted. Otherwise `stall`=1 for exactly N cycles and `go`=1 in the next cycle. `go` is never high without `req_valid`, and `stall`=`req_valid` AND NOT `go`.
- R10: Consider chip select 0 with float 6, optimization set, and a read ending with hold 4. A write to another chip select with setup 3, requested in that cycle, waits exactly 1 cycle, which is the turnaround. A read to another chip select in that cycle waits 0 cycles.
- R11: A request in the same cycle as `rd_end` sees that read's float count and turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| float_cfg | input | NCS*CW | Float cycle count for each chip select, CW bits per chip select |
| opt_cfg | input | NCS | Per chip select: let the next access's setup absorb float time |
| rd_end | input | 1 | Last cycle of a read (its final hold cycle) |
| rd_cs | input | CSW | Chip select of the ending read |
| rd_hold | input | CW | Hold length of the ending read |
| req_valid | input | 1 | Next access is waiting to start |
| req_cs | input | CSW | Chip select of the next access |
| req_write | input | 1 | Next access is a write |
| req_setup | input | CW | Setup length of the next access |
| stall | output | 1 | Next access must wait this cycle |
| go | output | 1 | Next access may start this cycle |

## Verification
The bench builds the block with its defaults of four chip selects and 4-bit counts. With these values float counts up to 15 can exceed hold plus setup, which gives multi-cycle waits. Reads on two or three chip selects can also overlap, so the maximum across chip selects is exercised. Directed cases cover the configuration in R10, same-cycle arrival of a read end and a request, holds longer than the float count, and setup absorbing float time. Random traffic with changing configuration then compares every cycle of `stall` and `go` against a model built into the bench.

// File: rtl/float_gap_sched.sv
module float_gap_sched #(
  parameter int NCS = 4,
  parameter int CW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCS*CW-1:0]     float_cfg,
  input  logic [NCS-1:0]        opt_cfg,
  input  logic                  rd_end,
  input  logic [((NCS>1)?$clog2(NCS):1)-1:0] rd_cs,
  input  logic [CW-1:0]         rd_hold,
  input  logic                  req_valid,
  input  logic [((NCS>1)?$clog2(NCS):1)-1:0] req_cs,
  input  logic                  req_write,
  input  logic [CW-1:0]         req_setup,
  output logic                  stall,
  output logic                  go
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int TW  = CW + 1;

  function automatic logic [CW-1:0] sat_sub(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a - b : '0;
  endfunction

  logic [CW-1:0] rem_q [NCS];
  logic [CW-1:0] rem_v [NCS];
  logic          lr_q, lr_v, busy_q;
  logic [TW-1:0] wcnt_q, total;
  logic [CW-1:0] need;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign rem_v[g] = (rd_end && rd_cs == CSW'(g)) ?
                      sat_sub(float_cfg[g*CW +: CW], rd_hold) : rem_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) rem_q[g] <= '0;
      else        rem_q[g] <= sat_sub(rem_v[g], CW'(1));
    end

    p_float_decays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q[g] != '0 && !(rd_end && rd_cs == CSW'(g))) |=> (rem_q[g] < $past(rem_q[g])));
  end

  assign lr_v = lr_q | rd_end;

  always_comb begin
    logic [CW-1:0] eff;
    need = '0;
    for (int i = 0; i < NCS; i++) begin
      eff = sat_sub(rem_v[i], opt_cfg[i] ? req_setup : '0);
      if (CSW'(i) != req_cs && eff > need) need = eff;
    end
    total = TW'(need) + TW'(req_write && lr_v);
  end

  assign go    = req_valid && (busy_q ? (wcnt_q == '0) : (total == '0));
  assign stall = req_valid && !go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
      lr_q   <= 1'b0;
    end else begin
      lr_q <= go ? 1'b0 : lr_v;
      if (!busy_q) begin
        if (req_valid && total != '0) begin
          busy_q <= 1'b1;
          wcnt_q <= total - TW'(1);
        end
      end else if (wcnt_q != '0) begin
        wcnt_q <= wcnt_q - TW'(1);
      end else if (go) begin
        busy_q <= 1'b0;
      end
    end
  end

  p_go_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> req_valid);

  p_wait_blocks_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wcnt_q != '0) |-> !go);

  p_zero_wait_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_valid && total == '0) |-> go);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_valid && req_write && lr_v) |-> !go);

  p_go_clears_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !busy_q);
endmodule

// File: tb/float_gap_sched_tb_top.sv
module float_gap_sched_tb_top;
  localparam int NCS = 4;
  localparam int CW  = 4;
  localparam int CSW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCS*CW-1:0] float_cfg = '0;
  logic [NCS-1:0] opt_cfg = '0;
  logic rd_end = 1'b0;
  logic [CSW-1:0] rd_cs = '0;
  logic [CW-1:0] rd_hold = '0;
  logic req_valid = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic req_write = 1'b0;
  logic [CW-1:0] req_setup = '0;
  logic stall, go;

  always #4 clk = ~clk;

  float_gap_sched #(.NCS(NCS), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .float_cfg(float_cfg), .opt_cfg(opt_cfg),
    .rd_end(rd_end), .rd_cs(rd_cs), .rd_hold(rd_hold),
    .req_valid(req_valid), .req_cs(req_cs), .req_write(req_write),
    .req_setup(req_setup), .stall(stall), .go(go));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int rem_m [NCS];
  int busy_m, wcnt_m, lr_m;
  int last_go;

  function automatic int sat(int v);
    return (v > 0) ? v : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCS; i++) rem_m[i] = 0;
    busy_m = 0; wcnt_m = 0; lr_m = 0;
  endtask

  task automatic set_float(int cs, int v, bit opt);
    float_cfg[cs*CW +: CW] = CW'(v);
    opt_cfg[cs] = opt;
  endtask

  task automatic tick(string tag);
    int vv [NCS];
    int lrv, need, n, eg;
    #1;
    for (int i = 0; i < NCS; i++)
      vv[i] = (rd_end && int'(rd_cs) == i) ? sat(int'(float_cfg[i*CW +: CW]) - int'(rd_hold)) : rem_m[i];
    lrv = lr_m | int'(rd_end);
    need = 0;
    for (int i = 0; i < NCS; i++) begin
      int e;
      e = sat(vv[i] - (opt_cfg[i] ? int'(req_setup) : 0));
      if (i != int'(req_cs) && e > need) need = e;
    end
    n = need + ((req_write && lrv != 0) ? 1 : 0);
    if (busy_m != 0) eg = (req_valid && wcnt_m == 0) ? 1 : 0;
    else             eg = (req_valid && n == 0) ? 1 : 0;
    check({tag, " go"}, int'(go), eg);
    check({tag, " stall"}, int'(stall), (req_valid && eg == 0) ? 1 : 0);
    last_go = eg;
    @(posedge clk);
    if (busy_m == 0) begin
      if (req_valid && n > 0) begin busy_m = 1; wcnt_m = n - 1; end
    end else if (wcnt_m > 0) wcnt_m--;
    else if (eg != 0) busy_m = 0;
    lr_m = (eg != 0) ? 0 : lrv;
    for (int i = 0; i < NCS; i++) rem_m[i] = sat(vv[i] - 1);
    @(negedge clk);
  endtask

  task automatic idle(int k, string tag);
    for (int j = 0; j < k; j++) tick(tag);
  endtask

  task automatic rd_only(int cs, int hold, string tag);
    rd_end = 1; rd_cs = CSW'(cs); rd_hold = CW'(hold);
    tick(tag);
    rd_end = 0;
  endtask

  task automatic do_req(int cs, bit wr, int setup, int exp, string tag,
                        bit with_rd = 0, int rcs = 0, int rhold = 0);
    int lat;
    lat = 0;
    req_valid = 1; req_cs = CSW'(cs); req_write = wr; req_setup = CW'(setup);
    rd_end = with_rd; rd_cs = CSW'(rcs); rd_hold = CW'(rhold);
    tick(tag);
    rd_end = 0;
    while (last_go == 0 && lat < 40) begin
      lat++;
      tick(tag);
    end
    req_valid = 0;
    if (exp >= 0) check({tag, " latency"}, lat, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    set_float(0, 6, 1); set_float(1, 6, 0); set_float(2, 9, 0); set_float(3, 2, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: first accesses after reset start at once
    do_req(1, 0, 0, 0, "R1 read");
    do_req(2, 1, 0, 0, "R1 write");
    // R10 / R11: hold 4, setup 3, float 6, optimized
    do_req(1, 1, 3, 1, "R10 R11 write", 1, 0, 4);
    idle(16, "R3 idle");
    do_req(1, 0, 3, 0, "R10 read", 1, 0, 4);
    idle(16, "R3 idle");
    // R4: no optimization, full remaining float
    do_req(0, 0, 3, 2, "R4 plain", 1, 1, 4);
    idle(16, "R3 idle");
    // R3: one cycle elapsed
    rd_only(1, 4, "R2 load");
    do_req(0, 0, 0, 1, "R3 decay");
    idle(16, "R3 idle");
    // R6 / R8: same chip select
    do_req(2, 0, 0, 0, "R6 same cs read", 1, 2, 0);
    idle(16, "R3 idle");
    do_req(2, 1, 0, 1, "R6 R8 same cs write", 1, 2, 0);
    idle(16, "R3 idle");
    // R7: largest of several outstanding
    rd_only(2, 0, "R2 load");
    rd_only(1, 0, "R2 load");
    do_req(0, 0, 0, 7, "R7 max");
    idle(16, "R3 idle");
    // R5: setup absorbs
    do_req(3, 0, 2, 3, "R5 partial", 1, 0, 1);
    idle(16, "R3 idle");
    do_req(3, 0, 9, 0, "R5 full", 1, 0, 1);
    idle(16, "R3 idle");
    // R2: hold longer than float
    do_req(0, 0, 0, 0, "R2 long hold", 1, 1, 9);
    idle(16, "R3 idle");
    // R8: read ended earlier, write much later still turns around
    rd_only(3, 0, "R2 load");
    idle(8, "R3 idle");
    do_req(0, 1, 0, 1, "R8 late write");

    // random traffic, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = int'($urandom % 10);
      if (it % 300 == 0)
        for (int i = 0; i < NCS; i++) set_float(i, int'($urandom % 16), 1'($urandom % 2));
      if (op < 3) idle(1, "R9 rand idle");
      else if (op < 6) rd_only(int'($urandom % NCS), int'($urandom % 16), "R2 rand read");
      else do_req(int'($urandom % NCS), 1'($urandom % 2), int'($urandom % 16), -1,
                  "R9 rand req", 1'($urandom % 2), int'($urandom % NCS), int'($urandom % 16));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule